// File: doc/BRIEF.md
# Multi-format audio serial receiver

The block takes stereo PCM audio from a three-wire serial link (bit clock, word clock, data) and turns each frame into a pair of 24-bit two's complement samples, one for the left channel and one for the right. All three link signals are brought into the system clock domain through synchronisers. The system clock then detects the rising edges of the bit clock, and the data line and the word clock are sampled on those edges. A 3-bit format code picks one of six framings: left-justified, I2S, or right-justified at a word length of 24, 20, 18 or 16 bits.

Once per frame, after the right channel has finished, the block presents the left/right pair together with a one-cycle valid strobe. It counts the bit clocks in every word clock period and compares each count with the one from the period before. A change of count, a bit clock that stops, or a word clock that stays at one level for too long is taken as a loss of framing. On a loss the block zeroes its outputs, resynchronises by itself and stays muted for a fixed number of further frames. No external reset is needed to recover.

Top module: `audio_serial_rx`

## Requirements
- R1: During reset and just after it, `pair_valid` and `lock_lost` are 0, `left_out` and `right_out` are 0, and `muted_out` is 1.
- R2: With format code 101 (left-justified), the word clock is high for the left channel and low for the right. The MSB of a word is on the first bit-clock rise after the word clock edge. Bits are taken MSB first on bit-clock rising edges. Each half frame of 32 or 24 bit clocks yields its first 24 bits as the sample.
- R3: In left-justified mode at 16 bit clocks per half frame, the 16 received bits fill bits 23..8 of the sample, and bits 7..0 read 0.
- R4: With format code 100 (I2S), the word clock is low for the left channel and high for the right. The MSB is on the second bit-clock rise after the word clock edge. The mode works at 32 and 24 bit clocks per half frame.
- R5: Codes 000, 001, 010 and 011 select right-justified framing with words of 24, 20, 18 and 16 bits. The LSB is on the last bit clock of the half frame. The word is placed MSB-aligned at bit 23, with the unused low bits at 0.
- R6: `pair_valid` is high for exactly one system clock per frame. It is raised after the right channel of that frame completes, when the next left channel starts, and it carries the pair of the frame just completed.
- R7: When the number of bit clocks per word clock period differs from the previous period, `lock_lost` pulses and `muted_out` rises. With HOLD=3, the pairs of the first five frames at the new rate read 0, and from the sixth frame on the pairs carry data again.
- R8: If no bit-clock rise is seen for TIMEOUT system clocks, `lock_lost` pulses and `muted_out` is high. When the clocks resume, the block resynchronises by itself and later frames carry correct data.
- R9: Codes 110 and 111 are reserved. While one of them is selected, `muted_out` is 1 and every pair delivered reads 0.
- R10: If the word clock holds one level for more than MAX_HALF bit clocks, `lock_lost` pulses and `muted_out` rises.
- R11: Whenever `muted_out` is 1, `left_out` and `right_out` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4 times the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_in | input | 1 | Serial bit clock |
| wclk_in | input | 1 | Serial word clock (channel select) |
| sdata_in | input | 1 | Serial audio data |
| fmt_in | input | 3 | Framing code (000-011 right-justified 24/20/18/16, 100 I2S, 101 left-justified) |
| left_out | output | 24 | Left sample of the last completed frame |
| right_out | output | 24 | Right sample of the last completed frame |
| pair_valid | output | 1 | One-cycle strobe when a new pair is presented |
| muted_out | output | 1 | High while outputs are forced to zero |
| lock_lost | output | 1 | One-cycle pulse on each framing loss |

## Verification
The bench builds the block with its default parameters: MAX_HALF=32, TIMEOUT=64, HOLD=3 and two synchroniser stages. At these values a stuck word clock trips on the 33rd bit, and a bit clock that stops for a few hundred system clocks is a loss. The five-frame mute window after a rate change is short enough to count pair by pair. The bit clock runs at one eighth of the system clock, so frames of 64, 48 and 32 bit clocks fit in every format many times over.

// File: rtl/ars_pkg.sv
package ars_pkg;

  localparam int SAMPLE_W = 24;

  typedef enum logic [2:0] {
    FMT_RJ24 = 3'b000,
    FMT_RJ20 = 3'b001,
    FMT_RJ18 = 3'b010,
    FMT_RJ16 = 3'b011,
    FMT_I2S  = 3'b100,
    FMT_LJ   = 3'b101,
    FMT_RSV6 = 3'b110,
    FMT_RSV7 = 3'b111
  } fmt_e;

  function automatic logic fmt_is_i2s(input logic [2:0] f);
    return f == FMT_I2S;
  endfunction

  function automatic logic fmt_is_rj(input logic [2:0] f);
    return f[2] == 1'b0;
  endfunction

  function automatic logic fmt_reserved(input logic [2:0] f);
    return f[2:1] == 2'b11;
  endfunction

  // number of meaningful bits per channel word
  function automatic int word_len(input logic [2:0] f);
    case (f)
      FMT_RJ20: return 20;
      FMT_RJ18: return 18;
      FMT_RJ16: return 16;
      default:  return SAMPLE_W;
    endcase
  endfunction

  // slot index of the MSB inside a half frame of hlen bit clocks
  function automatic int first_slot(input logic [2:0] f, input int hlen);
    if (fmt_is_rj(f) && hlen > word_len(f)) return hlen - word_len(f);
    return 0;
  endfunction

endpackage

// File: rtl/ars_sync.sv
module ars_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], async_in[g]};
    end
    assign sync_out[g] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/ars_frame.sv
module ars_frame
  import ars_pkg::*;
#(
  parameter int MAX_HALF = 32,
  parameter int TIMEOUT  = 64,
  parameter int HOLD     = 3,
  localparam int IDX_W   = $clog2(MAX_HALF + 2),
  localparam int FCNT_W  = $clog2(2 * MAX_HALF + 2),
  localparam int TO_W    = $clog2(TIMEOUT + 1),
  localparam int UNMUTE  = 2 + HOLD,
  localparam int BND_W   = $clog2(UNMUTE + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_evt,
  input  logic             wclk_s,
  input  logic [2:0]       fmt,
  output logic [IDX_W-1:0] bit_idx,
  output logic [IDX_W-1:0] half_len,
  output logic             half_end,
  output logic             left_done,
  output logic             right_done,
  output logic             loss,
  output logic             muted
);

  localparam logic [IDX_W-1:0] IDX_MAX  = IDX_W'(MAX_HALF);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(MAX_HALF - 1);
  localparam logic [TO_W-1:0]  TO_LAST  = TO_W'(TIMEOUT - 1);
  localparam logic [TO_W-1:0]  TO_END   = TO_W'(TIMEOUT);
  localparam logic [BND_W-1:0] BND_FULL = BND_W'(UNMUTE);
  localparam logic [BND_W-1:0] BND_REF  = BND_W'(2);

  logic              w_d1_q, w_prev_q;
  logic [IDX_W-1:0]  idx_q, hlen_q;
  logic [FCNT_W-1:0] fcnt_q, ref_q;
  logic [TO_W-1:0]   tcnt_q;
  logic [BND_W-1:0]  bnd_q;

  logic w_eff, left_lvl, chg, ovf, to_hit, mismatch;

  // I2S is handled as left-justified with the word clock delayed one bit
  assign w_eff    = fmt_is_i2s(fmt) ? w_d1_q : wclk_s;
  assign left_lvl = fmt_is_i2s(fmt) ? ~w_eff : w_eff;
  assign chg      = bit_evt && (w_eff != w_prev_q);

  assign half_end   = chg;
  assign right_done = chg && left_lvl;
  assign left_done  = chg && !left_lvl;

  assign bit_idx  = chg ? '0 : ((idx_q == IDX_MAX) ? idx_q : idx_q + 1'b1);
  assign half_len = chg ? idx_q + 1'b1 : hlen_q;

  assign ovf      = bit_evt && !chg && (idx_q == IDX_LAST);
  assign to_hit   = !bit_evt && (tcnt_q == TO_LAST);
  assign mismatch = right_done && (bnd_q >= BND_REF) && (fcnt_q != ref_q);
  assign loss     = ovf || to_hit || mismatch;
  assign muted    = bnd_q < BND_FULL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_d1_q   <= 1'b0;
      w_prev_q <= 1'b0;
      idx_q    <= '0;
      hlen_q   <= '0;
      fcnt_q   <= '0;
    end else if (bit_evt) begin
      w_d1_q   <= wclk_s;
      w_prev_q <= w_eff;
      idx_q    <= bit_idx;
      if (chg) hlen_q <= idx_q + 1'b1;
      if (right_done)          fcnt_q <= FCNT_W'(1);
      else if (fcnt_q != '1)   fcnt_q <= fcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               tcnt_q <= '0;
    else if (bit_evt)         tcnt_q <= '0;
    else if (tcnt_q != TO_END) tcnt_q <= tcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bnd_q <= '0;
      ref_q <= '0;
    end else if (loss) begin
      bnd_q <= '0;
    end else if (right_done) begin
      if (bnd_q != '0) ref_q <= fcnt_q;
      if (bnd_q != BND_FULL) bnd_q <= bnd_q + 1'b1;
    end
  end

  // R7: any loss of framing mutes the outputs on the following cycle
  a_r7_loss_mutes: assert property (@(posedge clk) disable iff (!rst_n)
    loss |=> muted);

  // R7: muting ends only on a frame boundary
  a_r7_unmute_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(muted) |-> $past(right_done));

endmodule

// File: rtl/ars_capture.sv
module ars_capture
  import ars_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_evt,
  input  logic                data_s,
  input  logic [2:0]          fmt,
  input  logic [IDX_W-1:0]    bit_idx,
  input  logic [IDX_W-1:0]    half_len,
  input  logic                half_end,
  input  logic                left_done,
  input  logic                right_done,
  output logic [SAMPLE_W-1:0] left_q,
  output logic [SAMPLE_W-1:0] right_q,
  output logic                valid_q
);

  logic [SAMPLE_W-1:0] acc_q, acc_n, hold_l_q;
  int start, wl, rel;

  always_comb begin
    start = first_slot(fmt, int'(half_len));
    wl    = word_len(fmt);
    rel   = int'(bit_idx) - start;
    acc_n = half_end ? '0 : acc_q;
    if (rel >= 0 && rel < wl) acc_n[5'(SAMPLE_W - 1 - rel)] = data_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      hold_l_q <= '0;
      left_q   <= '0;
      right_q  <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= bit_evt && right_done;
      if (bit_evt) acc_q <= acc_n;
      if (left_done) hold_l_q <= acc_q;
      if (right_done) begin
        left_q  <= hold_l_q;
        right_q <= acc_q;
      end
    end
  end

  // R6: the pair strobe never lasts two cycles
  a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  // R6: the strobe follows completion of a right channel
  a_r6_valid_after_right: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> $past(right_done));

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import ars_pkg::*;
#(
  parameter int MAX_HALF    = 32,
  parameter int TIMEOUT     = 64,
  parameter int HOLD        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bclk_in,
  input  logic        wclk_in,
  input  logic        sdata_in,
  input  logic [2:0]  fmt_in,
  output logic [23:0] left_out,
  output logic [23:0] right_out,
  output logic        pair_valid,
  output logic        muted_out,
  output logic        lock_lost
);

  localparam int IDX_W = $clog2(MAX_HALF + 2);

  logic [2:0] link_s;
  logic       bclk_d_q, bit_evt;
  logic [IDX_W-1:0] bit_idx, half_len;
  logic half_end, left_done, right_done, frame_muted;
  logic [SAMPLE_W-1:0] left_q, right_q;

  ars_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({sdata_in, wclk_in, bclk_in}),
    .sync_out(link_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_d_q <= 1'b0;
    else        bclk_d_q <= link_s[0];
  end
  assign bit_evt = link_s[0] && !bclk_d_q;

  ars_frame #(.MAX_HALF(MAX_HALF), .TIMEOUT(TIMEOUT), .HOLD(HOLD)) u_frame (
    .clk(clk), .rst_n(rst_n), .bit_evt(bit_evt), .wclk_s(link_s[1]),
    .fmt(fmt_in), .bit_idx(bit_idx), .half_len(half_len),
    .half_end(half_end), .left_done(left_done), .right_done(right_done),
    .loss(lock_lost), .muted(frame_muted)
  );

  ars_capture #(.IDX_W(IDX_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .bit_evt(bit_evt), .data_s(link_s[2]),
    .fmt(fmt_in), .bit_idx(bit_idx), .half_len(half_len),
    .half_end(half_end), .left_done(left_done), .right_done(right_done),
    .left_q(left_q), .right_q(right_q), .valid_q(pair_valid)
  );

  assign muted_out = frame_muted || fmt_reserved(fmt_in);
  assign left_out  = muted_out ? '0 : left_q;
  assign right_out = muted_out ? '0 : right_q;

  // R6: a detected bit-clock rise is a single-cycle event
  a_r6_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
    bit_evt |=> !bit_evt);

  // R11: a pair strobe under mute carries zero data
  a_r11_muted_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid && muted_out) |-> (left_out == 24'd0 && right_out == 24'd0));

endmodule

// File: tb/sim_audio_serial_rx.sv
module sim_audio_serial_rx;

  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bclk = 1'b0, wclk = 1'b0, sdata = 1'b0;
  logic [2:0] fmt = 3'b101;
  logic [23:0] left_out, right_out;
  logic pair_valid, muted_out, lock_lost;

  int checks = 0, errors = 0;
  int good_cnt = 0, mute_cnt = 0, lost_cnt = 0;
  int cur_h = 32;
  logic prev_bit = 1'b0;
  logic [23:0] exp_l = '0, exp_r = '0;
  string cur_req = "R2";

  always #(CLK_PERIOD / 2) clk = ~clk;

  audio_serial_rx u0 (
    .clk(clk), .rst_n(rst_n), .bclk_in(bclk), .wclk_in(wclk),
    .sdata_in(sdata), .fmt_in(fmt), .left_out(left_out),
    .right_out(right_out), .pair_valid(pair_valid),
    .muted_out(muted_out), .lock_lost(lock_lost)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic int bench_len(input logic [2:0] f);
    if (f == 3'b001) return 20;
    if (f == 3'b010) return 18;
    if (f == 3'b011) return 16;
    return 24;
  endfunction

  // data line bit in slot i of a half frame of h bits (before I2S delay)
  function automatic logic line_bit(input logic [2:0] f, input int h,
                                    input logic [23:0] s, input int i);
    int l, st;
    l = bench_len(f);
    if (f[2] == 1'b0) begin
      st = h - l;
      if (i >= st) return s[23 - (i - st)];
      return 1'b0;
    end
    if (i < 24) return s[23 - i];
    return 1'b0;
  endfunction

  function automatic logic [23:0] exp_word(input logic [2:0] f, input int h,
                                           input logic [23:0] s);
    int l;
    l = (f[2] == 1'b0) ? bench_len(f) : ((h < 24) ? h : 24);
    return s & (24'hFFFFFF << (24 - l));
  endfunction

  task automatic send_bit(input logic w, input logic d);
    wclk  = w;
    sdata = d;
    repeat (4) @(negedge clk);
    bclk = 1'b1;
    repeat (4) @(negedge clk);
    bclk = 1'b0;
  endtask

  task automatic send_frame(input logic [23:0] l, input logic [23:0] r);
    logic i2s, cur, lvl;
    logic [23:0] s;
    i2s = (fmt == 3'b100);
    for (int half = 0; half < 2; half++) begin
      s   = (half == 0) ? l : r;
      lvl = (half == 0) ? !i2s : i2s;
      for (int i = 0; i < cur_h; i++) begin
        cur = line_bit(fmt, cur_h, s, i);
        send_bit(lvl, i2s ? prev_bit : cur);
        prev_bit = cur;
      end
    end
    exp_l = exp_word(fmt, cur_h, l);
    exp_r = exp_word(fmt, cur_h, r);
  endtask

  task automatic send_frames(input int n);
    for (int k = 0; k < n; k++)
      send_frame(24'($urandom), 24'($urandom));
  endtask

  task automatic clear_counts();
    good_cnt = 0; mute_cnt = 0; lost_cnt = 0;
  endtask

  task automatic stop_clocks();
    repeat (200) @(negedge clk);
  endtask

  task automatic run_phase(input logic [2:0] f, input int h, input string req);
    stop_clocks();
    fmt = f; cur_h = h; cur_req = req; prev_bit = 1'b0;
    clear_counts();
    send_frames(10);
    chk(good_cnt >= 4, req, "good pairs in phase", good_cnt, 4);
  endtask

  // monitor: every pair strobe is checked
  always @(negedge clk) if (rst_n) begin
    if (lock_lost) lost_cnt++;
    if (pair_valid) begin
      if (muted_out) begin
        mute_cnt++;
        chk(left_out == 0 && right_out == 0, "R11", "muted pair",
            int'(left_out | right_out), 0);
      end else begin
        good_cnt++;
        chk(left_out == exp_l, cur_req, "left sample", int'(left_out), int'(exp_l));
        chk(right_out == exp_r, cur_req, "right sample", int'(right_out), int'(exp_r));
      end
    end
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd7321);
    repeat (3) @(negedge clk);
    chk(!pair_valid && !lock_lost, "R1", "strobes in reset", {pair_valid, lock_lost}, 0);
    chk(left_out == 0 && right_out == 0, "R1", "data in reset", int'(left_out | right_out), 0);
    chk(muted_out, "R1", "muted in reset", muted_out, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(muted_out && !pair_valid, "R1", "state after reset", {muted_out, pair_valid}, 2);

    // left-justified, 64 and directed corner values
    fmt = 3'b101; cur_h = 32; cur_req = "R2";
    send_frames(6);
    send_frame(24'h800000, 24'h000001);
    send_frame(24'h7FFFFF, 24'hFFFFFF);
    send_frames(2);
    chk(good_cnt >= 3, "R2", "good pairs at 64 bits", good_cnt, 3);

    // rate change 64 -> 48 bit clocks per frame
    clear_counts(); cur_h = 24; cur_req = "R7";
    send_frames(8);
    chk(lost_cnt == 1, "R7", "loss pulses on rate change", lost_cnt, 1);
    chk(mute_cnt == HOLD + 2, "R7", "zero pairs after rate change", mute_cnt, HOLD + 2);
    chk(good_cnt == 3, "R7", "good pairs around rate change", good_cnt, 3);

    // bit clock stop
    clear_counts();
    stop_clocks();
    chk(lost_cnt == 1, "R8", "loss pulse on stopped clock", lost_cnt, 1);
    chk(muted_out, "R8", "muted while stopped", muted_out, 1);
    cur_req = "R8"; cur_h = 24;
    send_frames(8);
    chk(good_cnt >= 3, "R8", "recovery without reset", good_cnt, 3);

    run_phase(3'b101, 24, "R2");
    run_phase(3'b101, 16, "R3");
    run_phase(3'b100, 32, "R4");
    run_phase(3'b100, 24, "R4");
    run_phase(3'b000, 32, "R5");
    run_phase(3'b001, 32, "R5");
    run_phase(3'b010, 32, "R5");
    run_phase(3'b011, 32, "R5");
    run_phase(3'b011, 16, "R5");

    // stuck word clock
    run_phase(3'b101, 32, "R10");
    clear_counts();
    for (int i = 0; i < 40; i++) send_bit(1'b1, 1'b0);
    chk(lost_cnt == 1, "R10", "loss on stuck word clock", lost_cnt, 1);
    chk(muted_out, "R10", "muted after stuck word clock", muted_out, 1);
    send_frames(10);
    chk(good_cnt >= 4, "R10", "recovery after stuck word clock", good_cnt, 4);

    // reserved code
    stop_clocks();
    fmt = 3'b110; cur_h = 32; cur_req = "R9";
    clear_counts();
    send_frames(8);
    chk(good_cnt == 0, "R9", "unmuted pairs under reserved code", good_cnt, 0);
    chk(mute_cnt >= 6, "R9", "zero pairs under reserved code", mute_cnt, 6);
    chk(muted_out, "R9", "muted under reserved code", muted_out, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule